// File: doc/BRIEF.md
# Synchronization Command Hold Controller

This block sits on the microphone side of a digital microphone link and owns the control word that tunes the sampling-clock oscillator through a DAC. It takes command/data records that an upstream decoder has already pulled out of the remote-control pulse stream. Each record is a one-cycle strobe with an 8-bit command code and a 13-bit payload. Only the synchronization command (code 3) has any effect here. Its payload carries the new control value, left-justified, and the block keeps as many upper bits as the configured word width allows.

After power-up the block is in free-running mode 1, with the control word at mid-scale, which is the default-rate setting. The first synchronization command moves it into locked mode 2, and it stays there until the next reset. If the commands stop while locked, the block keeps the last control value and raises a sync-lost flag once a programmable number of cycles has passed. The next synchronization command clears that flag. An identification-request output tells the audio path to advertise mode 2 capability in its user data bits. It is raised whenever the block is not being actively steered, which means it is in mode 1 or the sync-lost flag is set.

Top module: `sync_hold_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `ctrl_word` equals mid-scale (only the MSB set; 12'h800 for the default width of 12), `mode2` is 0, `sync_lost` is 0 and `ident_req` is 1.
- R2: A record with `cmd_valid`=1 and `cmd_code`=8'd3 loads `ctrl_word` with `cmd_payload[12 -: CW_W]`, the upper CW_W bits of the payload. The new value is visible after that clock edge.
- R3: The first accepted code-3 record sets `mode2` to 1 at the same edge. `mode2` then stays 1 until reset.
- R4: A record with any other code, or with `cmd_valid`=0, leaves `ctrl_word`, `mode2` and `sync_lost` unchanged.
- R5: In mode 2, if no code-3 record is accepted at the next `timeout_limit` edges after an accepted one, `sync_lost` rises at exactly the `timeout_limit`-th edge. `ctrl_word` keeps its last value and `mode2` stays 1.
- R6: An accepted code-3 record clears `sync_lost` at its edge, at the same edge that loads the new value.
- R7: If a code-3 record is accepted at the very edge at which the timeout would expire, the record takes precedence. `sync_lost` stays 0 and the timeout window starts again from that edge.
- R8: `ident_req` is 1 exactly when `mode2` is 0 or `sync_lost` is 1.
- R9: In mode 1 no timeout runs: `sync_lost` stays 0 for any length of time without commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command/data record |
| cmd_code | input | 8 | Command code of the record |
| cmd_payload | input | 13 | Data payload, control value left-justified |
| timeout_limit | input | TMO_W | Cycles without a sync command before sync-lost |
| ctrl_word | output | CW_W | Oscillator-tuning control word |
| mode2 | output | 1 | 1 = locked mode 2, 0 = free-running mode 1 |
| sync_lost | output | 1 | Commands have stopped while locked |
| ident_req | output | 1 | Ask the audio path to advertise mode 2 capability |

## Verification
Two functions can land on the same edge: the expiry of the timeout and the arrival of a fresh synchronization command. The bench provokes this by sending one command and then sending the next so that it lands exactly `timeout_limit` edges later. The edge is judged correct if `sync_lost` stays 0 there, the new value is loaded, and the flag then rises `timeout_limit` edges after this second command rather than the first. A command given one edge after expiry shows the other order, where the flag is first set and then cleared.

// File: rtl/sync_hold_pkg.sv
package sync_hold_pkg;

  localparam int CODE_W    = 8;
  localparam int PAYLOAD_W = 13;

  // Code of the synchronization command; its value is part of the link protocol.
  localparam logic [CODE_W-1:0] SYNC_CODE = 8'd3;

  typedef enum logic {
    MODE_FREE   = 1'b0,
    MODE_LOCKED = 1'b1
  } op_mode_t;

endpackage

// File: rtl/sync_cmd_filter.sv
// Picks synchronization records out of the command stream and aligns the payload.
module sync_cmd_filter
  import sync_hold_pkg::*;
#(
  parameter int CW_W = 12
) (
  input  logic                 rec_valid,
  input  logic [CODE_W-1:0]    rec_code,
  input  logic [PAYLOAD_W-1:0] rec_payload,
  output logic                 hit,
  output logic [CW_W-1:0]      word
);

  localparam int DROP_W = PAYLOAD_W - CW_W;

  assign hit = rec_valid && (rec_code == SYNC_CODE);

  generate
    if (DROP_W == 0) begin : g_full
      assign word = rec_payload;
    end else begin : g_trim
      logic drop_unused;
      assign word        = rec_payload[PAYLOAD_W-1 -: CW_W];
      assign drop_unused = ^rec_payload[DROP_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sync_mode_fsm.sv
// Mode 1 until the first sync command, then mode 2 until reset.
module sync_mode_fsm
  import sync_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hit,
  output op_mode_t mode_q,
  output op_mode_t mode_d
);

  always_comb begin
    mode_d = mode_q;
    if (hit) mode_d = MODE_LOCKED;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_FREE;
    else     mode_q <= mode_d;
  end

endmodule

// File: rtl/sync_loss_timer.sv
// Counts edges since the last sync command while locked and flags expiry.
module sync_loss_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             kick,
  input  logic [TMO_W-1:0] limit,
  output logic             lost_q,
  output logic             lost_d
);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [TMO_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (TMO_W+1)'(1);

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (kick) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (armed && !lost_q) begin
      cnt_d = cnt_inc[TMO_W-1:0];
      if (cnt_inc >= {1'b0, limit}) lost_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

endmodule

// File: rtl/sync_hold_ctrl.sv
module sync_hold_ctrl
  import sync_hold_pkg::*;
#(
  parameter int CW_W  = 12,
  parameter int TMO_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [7:0]           cmd_code,
  input  logic [12:0]          cmd_payload,
  input  logic [TMO_W-1:0]     timeout_limit,
  output logic [CW_W-1:0]      ctrl_word,
  output logic                 mode2,
  output logic                 sync_lost,
  output logic                 ident_req
);

  localparam logic [CW_W-1:0] MID_SCALE = CW_W'(1) << (CW_W - 1);

  logic            hit;
  logic [CW_W-1:0] new_word;
  op_mode_t        mode_q, mode_d;
  logic            lost_q, lost_d;
  logic [CW_W-1:0] word_q;
  logic            ident_q;

  sync_cmd_filter #(.CW_W(CW_W)) u_filter (
    .rec_valid   (cmd_valid),
    .rec_code    (cmd_code),
    .rec_payload (cmd_payload),
    .hit         (hit),
    .word        (new_word)
  );

  sync_mode_fsm u_mode (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .mode_q (mode_q),
    .mode_d (mode_d)
  );

  sync_loss_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .armed  (mode_q == MODE_LOCKED),
    .kick   (hit),
    .limit  (timeout_limit),
    .lost_q (lost_q),
    .lost_d (lost_d)
  );

  // Control word: loaded by sync commands, held otherwise.
  always_ff @(posedge clk) begin
    if (rst)      word_q <= MID_SCALE;
    else if (hit) word_q <= new_word;
  end

  // Identification request, registered from next-state values.
  always_ff @(posedge clk) begin
    if (rst) ident_q <= 1'b1;
    else     ident_q <= (mode_d == MODE_FREE) || lost_d;
  end

  assign ctrl_word = word_q;
  assign mode2     = (mode_q == MODE_LOCKED);
  assign sync_lost = lost_q;
  assign ident_req = ident_q;

endmodule

// File: rtl/sync_hold_ctrl_chk.sv
module sync_hold_ctrl_chk #(
  parameter int CW_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [7:0]      cmd_code,
  input logic [12:0]     cmd_payload,
  input logic [CW_W-1:0] ctrl_word,
  input logic            mode2,
  input logic            sync_lost,
  input logic            ident_req
);

  logic            sync_in;
  logic [CW_W-1:0] exp_word;
  logic            chk_unused;

  assign sync_in    = cmd_valid && (cmd_code == 8'd3);
  assign exp_word   = cmd_payload[12 -: CW_W];
  assign chk_unused = ^cmd_payload;

  AST_LOAD_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> ctrl_word == $past(exp_word)); // R2

  AST_ENTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> mode2); // R3

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode2 |=> mode2); // R3

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    !sync_in |=> $stable(ctrl_word)); // R4

  AST_CLEAR_LOST: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> !sync_lost); // R6

  AST_NO_LOST_FREE: assert property (@(posedge clk) disable iff (rst)
    !mode2 |-> !sync_lost); // R9

  AST_IDENT_RULE: assert property (@(posedge clk) disable iff (rst)
    ident_req == (!mode2 || sync_lost)); // R8

endmodule

bind sync_hold_ctrl sync_hold_ctrl_chk #(.CW_W(CW_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .cmd_payload (cmd_payload),
  .ctrl_word   (ctrl_word),
  .mode2       (mode2),
  .sync_lost   (sync_lost),
  .ident_req   (ident_req)
);

// File: tb/sync_hold_ctrl_tb.sv
module sync_hold_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW_W  = 12;
  localparam int TMO_W = 16;
  localparam int NVEC  = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             cmd_valid;
  logic [7:0]       cmd_code;
  logic [12:0]      cmd_payload;
  logic [TMO_W-1:0] timeout_limit;
  logic [CW_W-1:0]  ctrl_word;
  logic             mode2, sync_lost, ident_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_hold_ctrl #(.CW_W(CW_W), .TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_payload(cmd_payload), .timeout_limit(timeout_limit),
    .ctrl_word(ctrl_word), .mode2(mode2), .sync_lost(sync_lost),
    .ident_req(ident_req)
  );

  // {valid, code[7:0], payload[12:0], exp_ctrl[11:0], exp_mode2}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0, 8'd3,   13'h1FFF, 12'h800, 1'b0},  // R4 no strobe
    {1'b1, 8'd2,   13'h0AAA, 12'h800, 1'b0},  // R4 other code
    {1'b1, 8'd3,   13'h1234, 12'h91A, 1'b1},  // R2 R3 first sync
    {1'b1, 8'd4,   13'h0000, 12'h91A, 1'b1},  // R4
    {1'b1, 8'd3,   13'h0001, 12'h000, 1'b1},  // R2 LSB dropped
    {1'b1, 8'd3,   13'h1FFF, 12'hFFF, 1'b1},  // R2 full scale
    {1'b1, 8'h83,  13'h0000, 12'hFFF, 1'b1},  // R4 near-miss code
    {1'b0, 8'd3,   13'h0000, 12'hFFF, 1'b1}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] code, input logic [12:0] pl);
    cmd_valid   = 1'b1;
    cmd_code    = code;
    cmd_payload = pl;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ctrl in reset", 32'(ctrl_word), 32'h800);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cmd_valid = 1'b0;
    cmd_code = '0;
    cmd_payload = '0;
    timeout_limit = 16'd1000;
    do_reset();
    chk("R1 ctrl", 32'(ctrl_word), 32'h800);
    chk("R1 mode2", 32'(mode2), 0);
    chk("R1 sync_lost", 32'(sync_lost), 0);
    chk("R1 ident_req", 32'(ident_req), 1);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      cmd_valid   = VEC[i][34];
      cmd_code    = VEC[i][33:26];
      cmd_payload = VEC[i][25:13];
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R2/R4 ctrl vec", 32'(ctrl_word), 32'(VEC[i][12:1]));
      chk("R3 mode2 vec", 32'(mode2), 32'(VEC[i][0]));
      chk("R8 ident vec", 32'(ident_req), 32'(!VEC[i][0]));
    end

    // R9: no timeout in mode 1
    timeout_limit = 16'd5;
    do_reset();
    repeat (20) @(negedge clk);
    chk("R9 no lost in mode 1", 32'(sync_lost), 0);
    chk("R8 ident in mode 1", 32'(ident_req), 1);

    // R5: timeout in mode 2
    send(8'd3, 13'h0ABC);
    repeat (4) @(negedge clk);
    chk("R5 not yet lost", 32'(sync_lost), 0);
    chk("R8 ident locked", 32'(ident_req), 0);
    @(negedge clk);
    chk("R5 lost at limit", 32'(sync_lost), 1);
    chk("R5 ctrl held", 32'(ctrl_word), 32'h55E);
    chk("R5 mode2 held", 32'(mode2), 1);
    chk("R8 ident when lost", 32'(ident_req), 1);
    // R4: other code does not clear lost
    send(8'd1, 13'h0000);
    chk("R4 lost unchanged", 32'(sync_lost), 1);
    chk("R4 ctrl unchanged", 32'(ctrl_word), 32'h55E);

    // R6: next sync clears and loads
    send(8'd3, 13'h0246);
    chk("R6 lost cleared", 32'(sync_lost), 0);
    chk("R6 new value", 32'(ctrl_word), 32'h123);
    chk("R8 ident cleared", 32'(ident_req), 0);

    // R7: sync at the expiry edge wins
    repeat (4) @(negedge clk);
    send(8'd3, 13'h1000);
    chk("R7 no lost on tie", 32'(sync_lost), 0);
    chk("R7 value loaded", 32'(ctrl_word), 32'h800);
    repeat (4) @(negedge clk);
    chk("R7 window restarted", 32'(sync_lost), 0);
    @(negedge clk);
    chk("R7 lost after restart", 32'(sync_lost), 1);

    // R1: reset from locked state
    do_reset();
    chk("R1 mode2 after reset", 32'(mode2), 0);
    chk("R1 lost after reset", 32'(sync_lost), 0);
    chk("R1 ident after reset", 32'(ident_req), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule